// File: doc/BRIEF.md
# Exception Enable Qualifier

This block sits between the raw exception request lines of a processor core and its exception entry sequencer. For each cycle it decides which requests are allowed to be taken under the current machine state enable bits. It then presents at most one of them, the highest in a fixed order, as a one-hot take vector.

Synchronous conditions are qualified in the same cycle. These are system reset, machine check and the floating-point program exception. The two asynchronous sources, external interrupt and decrementer, are first captured into pending registers. While the external-enable bit is low they wait there and are not lost. A machine check whose enable bit is clear does not produce a take. It drives the core into a sticky checkstop state that only the hardware reset leaves.

Top module: `exq_qualifier`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it rises with no request asserted, `take_o` is 0, `checkstop_o` is 0 and both pending registers are empty.
- R2: The floating-point request is qualified when `fp_mode_i` is 01, 10 or 11, all treated alike, and produces `take_o[2]` in the same cycle. With `fp_mode_i` = 00 it is ignored and `take_o` stays 0.
- R3: An external request (`ext_req_i`) or decrementer request (`dec_req_i`) is captured at a rising clock edge. It produces `take_o[3]` or `take_o[4]` in the cycle after that edge, but only while `ext_en_i` is 1.
- R4: While `ext_en_i` is 0, a captured asynchronous request stays pending as long as its source holds it. It is taken in the first cycle in which `ext_en_i` reads 1. A request that its source drops before it is taken is discarded.
- R5: A pending asynchronous request is cleared by the clock edge that ends the cycle in which it was taken.
- R6: A machine-check condition exists when any bit of `mchk_src_i` is 1 together with the same bit of `mchk_mask_i`. Source bits whose mask bit is 0 have no effect. With `mchk_en_i` = 1 the condition produces `take_o[1]` in the same cycle.
- R7: A machine-check condition with `mchk_en_i` = 0 forces `take_o` to 0 in that cycle and sets `checkstop_o` at the next clock edge.
- R8: `checkstop_o` stays 1 until `rst_ni` goes low. While it is 1, `take_o` is 0 for every request, system reset included.
- R9: System reset (`sreset_req_i`) produces `take_o[0]` in the same cycle, whatever the enable bits are.
- R10: `take_o` has at most one bit set. The bit order is 0 system reset, 1 machine check, 2 program, 3 external, 4 decrementer, and a lower index wins. A request that loses stays pending when it is asynchronous and still held by its source.
- R11: A request that is not qualified, such as a floating-point request in mode 00, does not block a lower-priority qualified request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fp_mode_i | input | 2 | Floating-point exception mode; 00 disables |
| ext_en_i | input | 1 | External-enable bit for asynchronous sources |
| mchk_en_i | input | 1 | Machine-check enable bit |
| sreset_req_i | input | 1 | System reset request |
| mchk_src_i | input | NUM_MCHK_SRC | Machine-check source conditions |
| mchk_mask_i | input | NUM_MCHK_SRC | Per-source machine-check enables |
| fp_exc_req_i | input | 1 | Floating-point enabled exception request |
| ext_req_i | input | 1 | External interrupt request (level) |
| dec_req_i | input | 1 | Decrementer request (level) |
| take_o | output | 5 | One-hot take vector |
| checkstop_o | output | 1 | Sticky checkstop state |

## Verification
Two functions can meet in one cycle: a synchronous program exception and a pending external request that has just become unmasked. The bench provokes this by latching an external request while the enable is low. It then raises the enable in the same cycle as a floating-point request. It expects the program take first and the external take in the following cycle, which shows that the loser stayed pending. A disabled machine check in the same cycle as a system reset is handled the same way. The expected result there is no take at all, and checkstop on the next edge.

// File: rtl/exq_pkg.sv
`timescale 1ns/1ps
package exq_pkg;
  localparam int unsigned NUM_EXC  = 5;
  localparam int unsigned NUM_ASYNC = 2;
  // take vector bit positions, lower wins
  localparam int unsigned IDX_SRESET = 0;
  localparam int unsigned IDX_MCHK   = 1;
  localparam int unsigned IDX_PROG   = 2;
  localparam int unsigned IDX_EXT    = 3;
  localparam int unsigned IDX_DEC    = 4;
endpackage

// File: rtl/exq_async_hold.sv
`timescale 1ns/1ps
module exq_async_hold #(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] take_i,
  output logic [NUM_SRC-1:0] pend_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic pend_q;
    // held while source asserts, dropped on take or release
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= 1'b0;
      else         pend_q <= req_i[g] & ~take_i[g];
    end
    assign pend_o[g] = pend_q;

    // R4
    pend_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i[g] && !take_i[g]) |=> pend_o[g]);
    // R5
    pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      take_i[g] |=> !pend_o[g]);
  end
endmodule

// File: rtl/exq_mchk_gate.sv
`timescale 1ns/1ps
module exq_mchk_gate #(
  parameter int unsigned NUM_SRC = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic               en_i,
  output logic               take_req_o,
  output logic               cs_cond_o,
  output logic               checkstop_o
);
  logic hit;
  logic cs_q;

  assign hit        = |(src_i & mask_i);
  assign take_req_o = hit & en_i;
  assign cs_cond_o  = hit & ~en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cs_q <= 1'b0;
    else if (cs_cond_o) cs_q <= 1'b1;
  end
  assign checkstop_o = cs_q;

  // R7
  cs_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_cond_o |=> checkstop_o);
  // R8
  cs_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    checkstop_o |=> checkstop_o);
endmodule

// File: rtl/exq_prio_pick.sv
`timescale 1ns/1ps
module exq_prio_pick #(
  parameter int unsigned NUM_REQ = 5
) (
  input  logic [NUM_REQ-1:0] req_i,
  input  logic               kill_i,
  output logic [NUM_REQ-1:0] grant_o
);
  logic [NUM_REQ-1:0] blocked;

  assign blocked[0] = kill_i;
  for (genvar g = 1; g < NUM_REQ; g++) begin : g_chain
    assign blocked[g] = blocked[g-1] | req_i[g-1];
  end

  assign grant_o = req_i & ~blocked;
endmodule

// File: rtl/exq_qualifier.sv
`timescale 1ns/1ps
module exq_qualifier
  import exq_pkg::*;
#(
  parameter int unsigned NUM_MCHK_SRC = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [1:0]              fp_mode_i,
  input  logic                    ext_en_i,
  input  logic                    mchk_en_i,
  input  logic                    sreset_req_i,
  input  logic [NUM_MCHK_SRC-1:0] mchk_src_i,
  input  logic [NUM_MCHK_SRC-1:0] mchk_mask_i,
  input  logic                    fp_exc_req_i,
  input  logic                    ext_req_i,
  input  logic                    dec_req_i,
  output logic [NUM_EXC-1:0]      take_o,
  output logic                    checkstop_o
);
  logic                 fp_en;
  logic                 mchk_take_req;
  logic                 cs_cond;
  logic                 kill;
  logic [NUM_ASYNC-1:0] async_req;
  logic [NUM_ASYNC-1:0] async_pend;
  logic [NUM_ASYNC-1:0] async_take;
  logic [NUM_EXC-1:0]   qual;

  // any nonzero mode enables the floating-point path
  assign fp_en = |fp_mode_i;

  exq_mchk_gate #(.NUM_SRC(NUM_MCHK_SRC)) mchk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_i       (mchk_src_i),
    .mask_i      (mchk_mask_i),
    .en_i        (mchk_en_i),
    .take_req_o  (mchk_take_req),
    .cs_cond_o   (cs_cond),
    .checkstop_o (checkstop_o)
  );

  assign async_req  = {dec_req_i, ext_req_i};
  assign async_take = {take_o[IDX_DEC], take_o[IDX_EXT]};

  exq_async_hold #(.NUM_SRC(NUM_ASYNC)) hold_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (async_req),
    .take_i (async_take),
    .pend_o (async_pend)
  );

  always_comb begin
    qual             = '0;
    qual[IDX_SRESET] = sreset_req_i;
    qual[IDX_MCHK]   = mchk_take_req;
    qual[IDX_PROG]   = fp_exc_req_i & fp_en;
    qual[IDX_EXT]    = async_pend[0] & ext_en_i;
    qual[IDX_DEC]    = async_pend[1] & ext_en_i;
  end

  // stopping core takes nothing, reset included
  assign kill = checkstop_o | cs_cond;

  exq_prio_pick #(.NUM_REQ(NUM_EXC)) pick_i (
    .req_i   (qual),
    .kill_i  (kill),
    .grant_o (take_o)
  );

  // R10
  take_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take_o));
  // R8
  cs_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    checkstop_o |-> (take_o == '0));
  // R2
  fp_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fp_mode_i == 2'b00) |-> !take_o[IDX_PROG]);
  // R3
  async_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_en_i |-> (take_o[IDX_DEC:IDX_EXT] == 2'b00));
  // R9
  sreset_take_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sreset_req_i && !checkstop_o && !cs_cond) |-> take_o[IDX_SRESET]);
endmodule

// File: tb/exq_qualifier_tb.sv
`timescale 1ns/1ps
module exq_qualifier_tb_top;
  localparam int NSRC = 4;
  localparam int NVEC = 13;
  localparam int WDOG = 200000;

  logic            clk = 1'b0;
  logic            rst_ni = 1'b0;
  logic [1:0]      fp_mode_i = '0;
  logic            ext_en_i = 1'b0;
  logic            mchk_en_i = 1'b0;
  logic            sreset_req_i = 1'b0;
  logic [NSRC-1:0] mchk_src_i = '0;
  logic [NSRC-1:0] mchk_mask_i = '1;
  logic            fp_exc_req_i = 1'b0;
  logic            ext_req_i = 1'b0;
  logic            dec_req_i = 1'b0;
  logic [4:0]      take_o;
  logic            checkstop_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  exq_qualifier #(.NUM_MCHK_SRC(NSRC)) dut_i (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .fp_mode_i    (fp_mode_i),
    .ext_en_i     (ext_en_i),
    .mchk_en_i    (mchk_en_i),
    .sreset_req_i (sreset_req_i),
    .mchk_src_i   (mchk_src_i),
    .mchk_mask_i  (mchk_mask_i),
    .fp_exc_req_i (fp_exc_req_i),
    .ext_req_i    (ext_req_i),
    .dec_req_i    (dec_req_i),
    .take_o       (take_o),
    .checkstop_o  (checkstop_o)
  );

  // {mode[1:0], ee, me, sreset, mchk, fp, ext, dec, exp_take[4:0]}
  localparam logic [13:0] VEC [NVEC] = '{
    14'b00_0_0_0_0_1_0_0_00000, // R2 mode 00 ignored
    14'b01_0_0_0_0_1_0_0_00100, // R2
    14'b10_0_0_0_0_1_0_0_00100, // R2
    14'b11_0_0_0_0_1_0_0_00100, // R2
    14'b00_1_0_0_0_0_1_0_01000, // R3
    14'b00_0_0_0_0_0_1_1_00000, // R3 masked
    14'b00_1_0_0_0_0_0_1_10000, // R3
    14'b00_1_0_0_0_0_1_1_01000, // R10
    14'b11_1_1_0_1_1_1_1_00010, // R10
    14'b11_1_1_1_1_1_1_1_00001, // R10
    14'b00_0_0_1_0_0_0_0_00001, // R9
    14'b00_1_0_0_0_1_1_0_01000, // R11
    14'b01_1_0_0_0_1_0_1_00100  // R10
  };

  function automatic string vtag(input int i);
    case (i)
      0, 1, 2, 3: return "R2";
      4, 5, 6:    return "R3";
      10:         return "R9";
      11:         return "R11";
      default:    return "R10";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle();
    fp_mode_i = '0; ext_en_i = 0; mchk_en_i = 0; sreset_req_i = 0;
    mchk_src_i = '0; mchk_mask_i = '1; fp_exc_req_i = 0; ext_req_i = 0; dec_req_i = 0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(20 * WDOG);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 take in reset", take_o, 5'b0);
    chk("R1 checkstop in reset", {4'b0, checkstop_o}, 5'b0);
    rst_ni = 1'b1;
    @(negedge clk); #1;
    chk("R1 take after reset", take_o, 5'b0);

    for (int i = 0; i < NVEC; i++) begin
      idle();
      fp_mode_i    = VEC[i][13:12];
      ext_en_i     = VEC[i][11];
      mchk_en_i    = VEC[i][10];
      sreset_req_i = VEC[i][9];
      mchk_src_i   = VEC[i][8] ? '1 : '0;
      fp_exc_req_i = VEC[i][7];
      ext_req_i    = VEC[i][6];
      dec_req_i    = VEC[i][5];
      @(negedge clk); #1;
      chk(vtag(i), take_o, VEC[i][4:0]);
    end

    // R6 per-source mask
    idle();
    mchk_en_i = 1; mchk_src_i = 4'b0100; mchk_mask_i = 4'b1011; #1;
    chk("R6 masked source", take_o, 5'b0);
    mchk_en_i = 0;
    @(negedge clk); #1;
    chk("R6 masked no checkstop", {4'b0, checkstop_o}, 5'b0);
    mchk_en_i = 1; mchk_mask_i = '1; #1;
    chk("R6 unmasked take", take_o, 5'b00010);

    // R4 deferral then take, R5 clear
    idle();
    ext_req_i = 1; #1;
    chk("R4 not yet captured", take_o, 5'b0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R4 held while masked", take_o, 5'b0);
    end
    ext_en_i = 1; #1;
    chk("R4 taken on enable", take_o, 5'b01000);
    @(negedge clk); #1;
    chk("R5 cleared after take", take_o, 5'b0);

    // R4 dropped before unmask
    idle();
    dec_req_i = 1;
    @(negedge clk);
    dec_req_i = 0;
    @(negedge clk);
    ext_en_i = 1; #1;
    chk("R4 released request discarded", take_o, 5'b0);

    // R10 same-cycle conflict, loser stays pending
    idle();
    ext_req_i = 1;
    @(negedge clk);
    ext_en_i = 1; fp_mode_i = 2'b11; fp_exc_req_i = 1; #1;
    chk("R10 program beats external", take_o, 5'b00100);
    @(negedge clk);
    fp_exc_req_i = 0; #1;
    chk("R10 external after program", take_o, 5'b01000);

    // R7 / R8 checkstop
    idle();
    mchk_src_i = 4'b0001; sreset_req_i = 1; #1;
    chk("R7 no take on checkstop condition", take_o, 5'b0);
    chk("R7 checkstop not before edge", {4'b0, checkstop_o}, 5'b0);
    @(negedge clk); #1;
    chk("R7 checkstop set", {4'b0, checkstop_o}, 5'b00001);
    mchk_src_i = '0; ext_en_i = 1; dec_req_i = 1; #1;
    chk("R8 sreset suppressed", take_o, 5'b0);
    repeat (3) @(negedge clk);
    #1;
    chk("R8 checkstop sticky", {4'b0, checkstop_o}, 5'b00001);
    chk("R8 async suppressed", take_o, 5'b0);
    rst_ni = 0; #1;
    chk("R1 reset clears checkstop", {4'b0, checkstop_o}, 5'b0);
    idle();
    rst_ni = 1;
    @(negedge clk);
    sreset_req_i = 1; #1;
    chk("R9 sreset after recovery", take_o, 5'b00001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule